// File: doc/BRIEF.md
# Receive Line Status Flags

This block keeps the three receive-side status flags of a serial port: data available, overrun error and parity error. It watches a strobe from the receive shift register that marks a finished character, the parity verdict computed for that character, the full and empty state of the receive FIFO, a FIFO-mode enable, reads of the receive buffer and reads of the status register. From these it drives a three-bit status word, which the register read path places in the low bits of the line status register, and a combinational `drop_char` signal that stops an overrunning character from being written into a full FIFO.

The block works in two modes. With FIFO mode off, a single holding register is assumed: the block tracks whether it holds an unread character, and a second character that arrives before that one is read destroys it and raises overrun. With FIFO mode on, data available follows the FIFO's non-empty state. A character that finishes while the FIFO is full is discarded rather than stored, and overrun is raised. The two error flags are sticky. A status register read clears them, unless a new error arrives in the same cycle.

Top module: `rx_line_status`

## Requirements
- R1: After a synchronous reset all three status bits and `drop_char` are 0.
- R2: With `fifo_mode` low, status bit 0 goes to 1 at the clock edge after a cycle with `char_done` high. It goes to 0 at the edge after a cycle with `rbr_read` high and `char_done` low. A cycle with both high leaves it at 1.
- R3: With `fifo_mode` high, status bit 0 takes the value of `!fifo_empty` sampled at the preceding clock edge.
- R4: With `fifo_mode` low, status bit 1 goes to 1 at the edge after a cycle where `char_done` is high, status bit 0 is already 1 and `rbr_read` is low.
- R5: With `fifo_mode` high, status bit 1 goes to 1 at the edge after a cycle where `char_done` and `fifo_full` are both high. A `rbr_read` in that same cycle does not prevent this.
- R6: `drop_char` is high, in the same cycle, exactly when `fifo_mode`, `char_done` and `fifo_full` are all high. It is never high with `fifo_mode` low.
- R7: Status bit 2 goes to 1 at the edge after a cycle where `char_done` and `par_err_in` are high and `drop_char` is low. A discarded character never sets it.
- R8: Status bits 1 and 2 go to 0 at the edge after a cycle with `lsr_read` high and no new event for that flag. `rbr_read` never clears them.
- R9: When a new overrun or parity event falls in the same cycle as `lsr_read`, the affected bit is 1 after that edge.
- R10: The error bits keep their value in any cycle without a set event or `lsr_read`. The bit positions are: 0 data available, 1 overrun, 2 parity error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_mode | input | 1 | 1 selects FIFO mode, 0 selects single holding register |
| char_done | input | 1 | One-cycle strobe: a character finished in the shift register |
| par_err_in | input | 1 | Parity verdict for the finishing character, 1 on mismatch |
| fifo_full | input | 1 | Receive FIFO holds no free entry |
| fifo_empty | input | 1 | Receive FIFO holds no entry |
| rbr_read | input | 1 | One-cycle strobe: receive buffer read |
| lsr_read | input | 1 | One-cycle strobe: line status register read |
| status_flags | output | 3 | Bit 0 data available, bit 1 overrun, bit 2 parity error |
| drop_char | output | 1 | Suppresses the transfer of the finishing character into the FIFO |

## Verification
The bench aims at the coincidences. A character and a buffer read in the same single-mode cycle must not count as overrun; a design that checked occupancy alone would report overrun on every back-to-back read. An error event in the same cycle as a status read must survive, while a design that gave the clear priority would lose it. A character arriving into a full FIFO must be dropped and must not set parity; a design that set parity here would report an error on a character software never sees. Mode switches mid-stream and buffer reads that must leave the error bits alone are mixed into long random runs, and a reference model is compared against the design every cycle.

// File: rtl/rx_lsr_pkg.sv
package rx_lsr_pkg;
  // width of the status word handed to the register read path
  localparam int unsigned LSR_W       = 3;
  // bit positions: the read path decodes these
  localparam int unsigned IDX_READY   = 0;
  localparam int unsigned IDX_OVERRUN = 1;
  localparam int unsigned IDX_PARITY  = 2;
  // number of sticky error flags and their slot in the error vector
  localparam int unsigned NUM_ERR     = 2;
  localparam int unsigned ERR_OVR     = 0;
  localparam int unsigned ERR_PAR     = 1;
endpackage

// File: rtl/rx_lsr_sticky.sv
// Sticky flag: a set event wins over a clear request in the same cycle.
module rx_lsr_sticky (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic clr_req,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (rst)          flag_q <= 1'b0;
    else if (set_evt) flag_q <= 1'b1;
    else if (clr_req) flag_q <= 1'b0;
  end
endmodule

// File: rtl/rx_lsr_ready.sv
// Data-available tracking for both buffer modes.
module rx_lsr_ready (
  input  logic clk,
  input  logic rst,
  input  logic fifo_mode,
  input  logic char_done,
  input  logic rbr_read,
  input  logic fifo_empty,
  output logic ready_q
);
  always_ff @(posedge clk) begin
    if (rst)            ready_q <= 1'b0;
    else if (fifo_mode) ready_q <= ~fifo_empty;
    else if (char_done) ready_q <= 1'b1;   // new char lands even if read now
    else if (rbr_read)  ready_q <= 1'b0;
  end
endmodule

// File: rtl/rx_lsr_events.sv
// Combinational event detection for overrun, parity and character drop.
module rx_lsr_events (
  input  logic fifo_mode,
  input  logic char_done,
  input  logic par_err_in,
  input  logic fifo_full,
  input  logic rbr_read,
  input  logic ready_q,
  output logic ovr_evt,
  output logic par_evt,
  output logic drop
);
  logic fifo_ovr;
  logic hold_ovr;

  always_comb begin
    // FIFO mode: full FIFO, the finishing character has nowhere to go
    fifo_ovr = fifo_mode & char_done & fifo_full;
    // single mode: unread character about to be overwritten
    hold_ovr = ~fifo_mode & char_done & ready_q & ~rbr_read;
    drop     = fifo_ovr;
    ovr_evt  = fifo_ovr | hold_ovr;
    par_evt  = char_done & par_err_in & ~fifo_ovr;
  end
endmodule

// File: rtl/rx_line_status.sv
module rx_line_status
  import rx_lsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_mode,
  input  logic             char_done,
  input  logic             par_err_in,
  input  logic             fifo_full,
  input  logic             fifo_empty,
  input  logic             rbr_read,
  input  logic             lsr_read,
  output logic [LSR_W-1:0] status_flags,
  output logic             drop_char
);
  logic               ready_q;
  logic               ovr_evt;
  logic               par_evt;
  logic [NUM_ERR-1:0] err_evt;
  logic [NUM_ERR-1:0] err_q;

  rx_lsr_ready u_ready (
    .clk        (clk),
    .rst        (rst),
    .fifo_mode  (fifo_mode),
    .char_done  (char_done),
    .rbr_read   (rbr_read),
    .fifo_empty (fifo_empty),
    .ready_q    (ready_q)
  );

  rx_lsr_events u_events (
    .fifo_mode  (fifo_mode),
    .char_done  (char_done),
    .par_err_in (par_err_in),
    .fifo_full  (fifo_full),
    .rbr_read   (rbr_read),
    .ready_q    (ready_q),
    .ovr_evt    (ovr_evt),
    .par_evt    (par_evt),
    .drop       (drop_char)
  );

  always_comb begin
    err_evt          = '0;
    err_evt[ERR_OVR] = ovr_evt;
    err_evt[ERR_PAR] = par_evt;
  end

  for (genvar g = 0; g < NUM_ERR; g++) begin : g_err
    rx_lsr_sticky u_flag (
      .clk     (clk),
      .rst     (rst),
      .set_evt (err_evt[g]),
      .clr_req (lsr_read),
      .flag_q  (err_q[g])
    );
  end

  always_comb begin
    status_flags              = '0;
    status_flags[IDX_READY]   = ready_q;
    status_flags[IDX_OVERRUN] = err_q[ERR_OVR];
    status_flags[IDX_PARITY]  = err_q[ERR_PAR];
  end
endmodule

// File: rtl/rx_line_status_chk.sv
module rx_line_status_chk (
  input logic       clk,
  input logic       rst,
  input logic       fifo_mode,
  input logic       char_done,
  input logic       par_err_in,
  input logic       fifo_full,
  input logic       fifo_empty,
  input logic       rbr_read,
  input logic       lsr_read,
  input logic [2:0] status_flags,
  input logic       drop_char
);
  assert_ready_on_char_R2: assert property (@(posedge clk) disable iff (rst)
    (!fifo_mode && char_done) |=> status_flags[0]);

  assert_fifo_ready_R3: assert property (@(posedge clk) disable iff (rst)
    (fifo_mode && !fifo_empty) |=> status_flags[0]);

  assert_single_overrun_R4: assert property (@(posedge clk) disable iff (rst)
    (!fifo_mode && char_done && status_flags[0] && !rbr_read) |=> status_flags[1]);

  assert_fifo_overrun_R5: assert property (@(posedge clk) disable iff (rst)
    (fifo_mode && char_done && fifo_full) |=> status_flags[1]);

  assert_no_drop_single_R6: assert property (@(posedge clk) disable iff (rst)
    !fifo_mode |-> !drop_char);

  assert_parity_set_R7: assert property (@(posedge clk) disable iff (rst)
    (char_done && par_err_in && !drop_char) |=> status_flags[2]);

  assert_lsr_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (lsr_read && !char_done) |=> (!status_flags[1] && !status_flags[2]));

  assert_err_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!char_done && !lsr_read) |=> $stable(status_flags[2:1]));
endmodule

bind rx_line_status rx_line_status_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .fifo_mode    (fifo_mode),
  .char_done    (char_done),
  .par_err_in   (par_err_in),
  .fifo_full    (fifo_full),
  .fifo_empty   (fifo_empty),
  .rbr_read     (rbr_read),
  .lsr_read     (lsr_read),
  .status_flags (status_flags),
  .drop_char    (drop_char)
);

// File: tb/sim_rx_line_status.sv
module sim_rx_line_status;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fifo_mode = 1'b0;
  logic       char_done = 1'b0;
  logic       par_err_in = 1'b0;
  logic       fifo_full = 1'b0;
  logic       fifo_empty = 1'b1;
  logic       rbr_read = 1'b0;
  logic       lsr_read = 1'b0;
  logic [2:0] status_flags;
  logic       drop_char;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // reference state
  int  m_held = 0;   // characters in the single holding register (0 or 1)
  bit  m_rdy  = 0;
  bit  m_ovr  = 0;
  bit  m_par  = 0;

  always #5 clk = ~clk;

  rx_line_status u0 (
    .clk(clk), .rst(rst), .fifo_mode(fifo_mode), .char_done(char_done),
    .par_err_in(par_err_in), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .rbr_read(rbr_read), .lsr_read(lsr_read),
    .status_flags(status_flags), .drop_char(drop_char)
  );

  // behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    bit lost, ovr_now, par_now;
    if (rst) begin
      m_held = 0; m_rdy = 0; m_ovr = 0; m_par = 0;
    end else begin
      lost    = fifo_mode && char_done && fifo_full;
      ovr_now = lost;
      if (fifo_mode) begin
        m_held = fifo_empty ? 0 : 1;
      end else begin
        if (char_done) begin
          if (m_held > 0 && !rbr_read) ovr_now = 1;
          m_held = 1;
        end else if (rbr_read) begin
          m_held = 0;
        end
      end
      par_now = char_done && par_err_in && !lost;
      m_rdy = (m_held > 0);
      if (ovr_now) m_ovr = 1; else if (lsr_read) m_ovr = 0;
      if (par_now) m_par = 1; else if (lsr_read) m_par = 0;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // compare registered flags (call just before new inputs are driven)
  task automatic compare_flags();
    check(status_flags[0] == m_rdy, fifo_mode ? "R3 ready" : "R2 ready",
          status_flags[0], m_rdy);
    check(status_flags[1] == m_ovr, "R4 R5 R8 R9 overrun", status_flags[1], m_ovr);
    check(status_flags[2] == m_par, "R7 R8 R9 R10 parity", status_flags[2], m_par);
  endtask

  task automatic drive(input bit fm, input bit cd, input bit pe, input bit ff,
                       input bit fe, input bit rr, input bit lr);
    @(negedge clk);
    compare_flags();
    fifo_mode = fm; char_done = cd; par_err_in = pe;
    fifo_full = ff; fifo_empty = fe; rbr_read = rr; lsr_read = lr;
    #1;
    check(drop_char == (fm && cd && ff), "R6 drop", drop_char, fm && cd && ff);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(status_flags == 3'b000, "R1 reset flags", status_flags, 0);
    check(drop_char == 1'b0, "R1 reset drop", drop_char, 0);

    // R2 / R4: single mode, char then char without read -> overrun
    drive(0,1,0,0,1,0,0);
    drive(0,1,0,0,1,0,0);
    drive(0,0,0,0,1,0,0);
    check(status_flags == 3'b011, "R4 R10 overrun bit1", status_flags, 3);
    // R8: rbr_read does not clear errors, clears ready
    drive(0,0,0,0,1,1,0);
    drive(0,0,0,0,1,0,0);
    check(status_flags == 3'b010, "R8 rbr keeps overrun", status_flags, 2);
    drive(0,0,0,0,1,0,1);
    drive(0,0,0,0,1,0,0);
    check(status_flags == 3'b000, "R8 lsr clears", status_flags, 0);
    // R2: char + read same cycle -> no overrun, ready stays
    drive(0,1,0,0,1,0,0);
    drive(0,1,0,0,1,1,0);
    drive(0,0,0,0,1,0,0);
    check(status_flags == 3'b001, "R2 read with char", status_flags, 1);
    // R9: parity event together with lsr_read
    drive(0,1,1,0,1,1,1);
    drive(0,0,0,0,1,0,0);
    check(status_flags == 3'b101, "R9 parity survives read", status_flags, 5);
    // R5 / R7: FIFO full, parity bad char dropped, read same cycle
    drive(0,0,0,0,1,0,1);
    drive(1,1,1,1,0,1,0);
    drive(1,0,0,1,0,0,0);
    check(status_flags == 3'b011, "R5 R7 dropped char", status_flags, 3);
    // R9 overrun with lsr_read in FIFO mode
    drive(1,1,0,1,0,0,1);
    drive(1,0,0,0,1,0,0);
    check(status_flags[1] == 1'b1, "R9 overrun survives read", status_flags[1], 1);
    drive(1,0,0,0,1,0,0);
    check(status_flags[0] == 1'b0, "R3 fifo empty", status_flags[0], 0);

    // random mixed stimulus with mode switches
    for (int i = 0; i < 4000; i++) begin
      bit fm, ff, fe;
      fm = ((i / 300) % 2) == 1;
      ff = ($urandom_range(0, 3) == 0);
      fe = ff ? 1'b0 : ($urandom_range(0, 2) == 0);
      drive(fm, $urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0, ff, fe,
            $urandom_range(0, 3) == 0, $urandom_range(0, 4) == 0);
    end
    drive(0,0,0,0,1,0,0);
    @(negedge clk);
    compare_flags();

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule